// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural registers of a 32-bit processor core whose visible register set depends on the current operating mode. A caller always sees sixteen numbered general registers, one current status word and, in exception modes, one saved status word. A 5-bit mode input selects which physical copy each logical index reaches. Registers 0 to 7 and the program counter (index 15) have a single copy. The fast-interrupt mode keeps private copies of indices 8 to 14. The other four exception modes (interrupt, supervisor, abort, undefined) keep private copies of indices 13 and 14 only.

Storage totals 37 words of 32 bits. There are 31 general words: 16 used by user and system mode, 7 private to fast-interrupt mode, and 2 for each of the four other exception modes. There are 6 status words: one current status word and five saved ones, one per exception mode. The block has two combinational read ports and one write port for the general registers, plus separate read and write access to the current status word and to the saved status word of the current mode. Writes take effect at the rising clock edge.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset clears every general register, the current status word and all five saved status words to zero.
- R2: Indices 0 to 7 and index 15 address one shared copy: a value written in any mode reads back the same in every mode.
- R3: In fast-interrupt mode, indices 8 to 14 reach a private copy. Writes there leave the copies seen by other modes unchanged, and writes from other modes do not reach it.
- R4: In interrupt, supervisor, abort and undefined mode, indices 13 and 14 reach a copy private to that mode, while indices 8 to 12 reach the user copy.
- R5: User mode and system mode reach exactly the same general registers.
- R6: The mode encodings are user 5'h01, fast-interrupt 5'h02, interrupt 5'h03, supervisor 5'h04, abort 5'h05, undefined 5'h06 and system 5'h07. Any other encoding behaves as user mode.
- R7: The two read ports are independent and combinational: each returns the register selected by its own index under the current mode, in the same cycle.
- R8: A read of the register being written in the same cycle returns the old value. The new value is visible from the next cycle.
- R9: The current status word is a single copy shared by all modes. A write in one mode is read back in every mode.
- R10: Each of the five exception modes has its own saved status word. A write in one exception mode is invisible to the other four.
- R11: In user, system or an unrecognised mode, the saved status read returns zero and a saved status write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 5 | Current processor mode encoding |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | 32 | General register write data |
| cur_st_we | input | 1 | Current status word write enable |
| cur_st_wdata | input | 32 | Current status word write data |
| cur_st_rd | output | 32 | Current status word value |
| sav_we | input | 1 | Saved status word write enable, current mode |
| sav_wdata | input | 32 | Saved status word write data |
| sav_rd | output | 32 | Saved status word of the current mode |

## Verification
The main stimulus writes a distinct tag value to one index in one mode and then reads that index back from other modes. This separates shared indices (0–7, 15) from the fast-interrupt bank (8–14) and from the two-register banks of the other exception modes. Reads of index 8 or 10 from a small-bank mode show that only 13 and 14 are banked there, while reads of 13 from user and fast-interrupt mode show that no exception copy leaks. System mode and an unrecognised encoding are read against user-mode writes, and saved status words are written in all five exception modes and then in user mode to show isolation and the ignored write. A same-cycle write and read of one index shows the old value first and the new value one cycle later.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

    localparam int DATA_W       = 32;
    localparam int IDX_W        = 4;
    localparam int MODE_W       = 5;
    localparam int SHARED_REGS  = 16;
    localparam int FAST_REGS    = 7;
    localparam int SMALL_REGS   = 2;
    localparam int SMALL_MODES  = 4;
    localparam int PHYS_GPR     = SHARED_REGS + FAST_REGS + SMALL_REGS * SMALL_MODES;
    localparam int PHYS_W       = $clog2(PHYS_GPR);
    localparam int SAVED_WORDS  = 5;
    localparam int SLOT_W       = $clog2(SAVED_WORDS);
    localparam int FAST_BASE    = SHARED_REGS;
    localparam int SMALL_BASE   = SHARED_REGS + FAST_REGS;
    localparam int FAST_LO      = 8;
    localparam int FAST_HI      = 14;
    localparam int SMALL_LO     = 13;

    localparam logic [MODE_W-1:0] MODE_USER = 5'h01;
    localparam logic [MODE_W-1:0] MODE_FAST = 5'h02;
    localparam logic [MODE_W-1:0] MODE_IRQ  = 5'h03;
    localparam logic [MODE_W-1:0] MODE_SVC  = 5'h04;
    localparam logic [MODE_W-1:0] MODE_ABT  = 5'h05;
    localparam logic [MODE_W-1:0] MODE_UND  = 5'h06;
    localparam logic [MODE_W-1:0] MODE_SYS  = 5'h07;

    typedef enum logic [2:0] {
        BK_USER = 3'd0,
        BK_FAST = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SVC  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5
    } bank_e;

    typedef struct packed {
        logic              en;
        logic [PHYS_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } gpr_wr_t;

    typedef struct packed {
        bank_e             bank;
        logic              has_saved;
        logic [SLOT_W-1:0] slot;
    } bank_sel_t;

    function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
        bank_e b;
        case (m)
            MODE_FAST: b = BK_FAST;
            MODE_IRQ:  b = BK_IRQ;
            MODE_SVC:  b = BK_SVC;
            MODE_ABT:  b = BK_ABT;
            MODE_UND:  b = BK_UND;
            default:   b = BK_USER;
        endcase
        return b;
    endfunction

    function automatic logic [PHYS_W-1:0] small_base(input bank_e b);
        logic [PHYS_W-1:0] base;
        case (b)
            BK_IRQ:  base = PHYS_W'(SMALL_BASE);
            BK_SVC:  base = PHYS_W'(SMALL_BASE + SMALL_REGS);
            BK_ABT:  base = PHYS_W'(SMALL_BASE + 2 * SMALL_REGS);
            default: base = PHYS_W'(SMALL_BASE + 3 * SMALL_REGS);
        endcase
        return base;
    endfunction

    function automatic logic [PHYS_W-1:0] phys_of(input bank_e b, input logic [IDX_W-1:0] idx);
        logic [PHYS_W-1:0] p;
        p = PHYS_W'(idx);
        case (b)
            BK_FAST: begin
                if (idx >= IDX_W'(FAST_LO) && idx <= IDX_W'(FAST_HI))
                    p = PHYS_W'(FAST_BASE) + PHYS_W'(idx) - PHYS_W'(FAST_LO);
            end
            BK_IRQ, BK_SVC, BK_ABT, BK_UND: begin
                if (idx == IDX_W'(SMALL_LO))
                    p = small_base(b);
                else if (idx == IDX_W'(SMALL_LO + 1))
                    p = small_base(b) + PHYS_W'(1);
            end
            default: p = PHYS_W'(idx);
        endcase
        return p;
    endfunction

endpackage

// File: rtl/banked_regfile_mode_dec.sv
module banked_regfile_mode_dec
    import banked_regfile_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_sel_t         sel
);
    always_comb begin
        sel.bank      = mode_to_bank(mode);
        sel.has_saved = (sel.bank != BK_USER);
        sel.slot      = (sel.bank == BK_USER) ? '0 : SLOT_W'(sel.bank) - SLOT_W'(1);
    end
endmodule

// File: rtl/banked_regfile_addr_map.sv
module banked_regfile_addr_map
    import banked_regfile_pkg::*;
#(
    parameter int NPORT = 3
) (
    input  bank_e                         bank,
    input  logic [NPORT-1:0][IDX_W-1:0]   idx,
    output logic [NPORT-1:0][PHYS_W-1:0]  phys
);
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        always_comb phys[g] = phys_of(bank, idx[g]);
    end
endmodule

// File: rtl/banked_regfile_gpr_store.sv
module banked_regfile_gpr_store
    import banked_regfile_pkg::*;
#(
    parameter int DEPTH = PHYS_GPR,
    parameter int NRD   = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  gpr_wr_t                         wr,
    input  logic [NRD-1:0][PHYS_W-1:0]      rd_addr,
    output logic [NRD-1:0][DATA_W-1:0]      rd_data
);
    logic [DATA_W-1:0] word_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                word_q[e] <= '0;
            else if (wr.en && wr.addr == PHYS_W'(e))
                word_q[e] <= wr.data;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        always_comb begin
            rd_data[r] = '0;
            for (int e = 0; e < DEPTH; e++)
                if (rd_addr[r] == PHYS_W'(e))
                    rd_data[r] = word_q[e];
        end
    end
endmodule

// File: rtl/banked_regfile_status.sv
module banked_regfile_status
    import banked_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bank_sel_t         sel,
    input  logic              cur_we,
    input  logic [DATA_W-1:0] cur_wdata,
    output logic [DATA_W-1:0] cur_rd,
    input  logic              sav_we,
    input  logic [DATA_W-1:0] sav_wdata,
    output logic [DATA_W-1:0] sav_rd
);
    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] sav_q [SAVED_WORDS];

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else if (cur_we)
            cur_q <= cur_wdata;
    end

    for (genvar s = 0; s < SAVED_WORDS; s++) begin : g_sav
        always_ff @(posedge clk) begin
            if (rst)
                sav_q[s] <= '0;
            else if (sav_we && sel.has_saved && sel.slot == SLOT_W'(s))
                sav_q[s] <= sav_wdata;
        end
    end

    always_comb begin
        cur_rd = cur_q;
        sav_rd = '0;
        if (sel.has_saved)
            for (int s = 0; s < SAVED_WORDS; s++)
                if (sel.slot == SLOT_W'(s))
                    sav_rd = sav_q[s];
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import banked_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        mode,
    input  logic [3:0]        rd_a_idx,
    output logic [31:0]       rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [31:0]       rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              cur_st_we,
    input  logic [31:0]       cur_st_wdata,
    output logic [31:0]       cur_st_rd,
    input  logic              sav_we,
    input  logic [31:0]       sav_wdata,
    output logic [31:0]       sav_rd
);
    localparam int NRD = 2;

    bank_sel_t                   sel;
    logic [NRD:0][IDX_W-1:0]     log_idx;
    logic [NRD:0][PHYS_W-1:0]    phys_idx;
    logic [NRD-1:0][PHYS_W-1:0]  rd_phys;
    logic [NRD-1:0][DATA_W-1:0]  rd_word;
    gpr_wr_t                     wr_req;

    banked_regfile_mode_dec u_dec (
        .mode (mode),
        .sel  (sel)
    );

    assign log_idx[0] = rd_a_idx;
    assign log_idx[1] = rd_b_idx;
    assign log_idx[2] = wr_idx;

    banked_regfile_addr_map #(.NPORT(NRD + 1)) u_map (
        .bank (sel.bank),
        .idx  (log_idx),
        .phys (phys_idx)
    );

    assign rd_phys[0] = phys_idx[0];
    assign rd_phys[1] = phys_idx[1];

    always_comb begin
        wr_req.en   = wr_en;
        wr_req.addr = phys_idx[2];
        wr_req.data = wr_data;
    end

    banked_regfile_gpr_store #(.DEPTH(PHYS_GPR), .NRD(NRD)) u_gpr (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_req),
        .rd_addr (rd_phys),
        .rd_data (rd_word)
    );

    assign rd_a_data = rd_word[0];
    assign rd_b_data = rd_word[1];

    banked_regfile_status u_st (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .cur_we    (cur_st_we),
        .cur_wdata (cur_st_wdata),
        .cur_rd    (cur_st_rd),
        .sav_we    (sav_we),
        .sav_wdata (sav_wdata),
        .sav_rd    (sav_rd)
    );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  mode,
    input logic [3:0]  rd_a_idx,
    input logic [31:0] rd_a_data,
    input logic [3:0]  rd_b_idx,
    input logic [31:0] rd_b_data,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic        cur_st_we,
    input logic [31:0] cur_st_wdata,
    input logic [31:0] cur_st_rd,
    input logic        sav_we,
    input logic [31:0] sav_wdata,
    input logic [31:0] sav_rd
);
    logic exc_mode;
    logic shared_idx;
    assign exc_mode   = (mode >= 5'h02) && (mode <= 5'h06);
    assign shared_idx = (wr_idx < 4'd8) || (wr_idx == 4'd15);

    // R2
    shared_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && shared_idx) |=> ((rd_a_idx == $past(wr_idx)) |-> (rd_a_data == $past(wr_data))));

    // R8
    write_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((mode == $past(mode) && rd_b_idx == $past(wr_idx)) |-> (rd_b_data == $past(wr_data))));

    // R9
    cur_status_chk: assert property (@(posedge clk) disable iff (rst)
        cur_st_we |=> (cur_st_rd == $past(cur_st_wdata)));

    // R10
    saved_status_chk: assert property (@(posedge clk) disable iff (rst)
        (sav_we && exc_mode) |=> ((mode == $past(mode)) |-> (sav_rd == $past(sav_wdata))));

    // R11
    saved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !exc_mode |-> (sav_rd == 32'h0));
endmodule

bind banked_regfile banked_regfile_chk u_chk (.*);

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mode = 5'h01;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, cur_st_we = 1'b0, sav_we = 1'b0;
    logic [31:0] cur_st_wdata = '0, cur_st_rd, sav_wdata = '0, sav_rd;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    banked_regfile u0 (.*);

    localparam int NV = 30;
    // {is_write, mode, index, data (write value or expected read)}
    localparam logic [41:0] VEC [NV] = '{
        {1'b1, 5'h01, 4'd0,  32'hA000_0000},  // R2
        {1'b1, 5'h02, 4'd0,  32'hA000_0001},  // R2
        {1'b1, 5'h01, 4'd8,  32'hB000_0008},  // R3
        {1'b1, 5'h02, 4'd8,  32'hF000_0008},  // R3
        {1'b1, 5'h04, 4'd13, 32'hC000_000D},  // R4
        {1'b1, 5'h03, 4'd13, 32'hD000_000D},  // R4
        {1'b1, 5'h05, 4'd14, 32'hE000_000E},  // R4
        {1'b1, 5'h06, 4'd14, 32'h9000_000E},  // R4
        {1'b1, 5'h07, 4'd9,  32'h7000_0009},  // R5
        {1'b1, 5'h01, 4'd15, 32'h0000_0F00},  // R2
        {1'b1, 5'h03, 4'd10, 32'h1000_000A},  // R4
        {1'b1, 5'h1F, 4'd12, 32'h1200_000C},  // R6
        {1'b0, 5'h01, 4'd0,  32'hA000_0001},  // R2
        {1'b0, 5'h03, 4'd0,  32'hA000_0001},  // R2
        {1'b0, 5'h01, 4'd8,  32'hB000_0008},  // R3
        {1'b0, 5'h02, 4'd8,  32'hF000_0008},  // R3
        {1'b0, 5'h04, 4'd8,  32'hB000_0008},  // R4
        {1'b0, 5'h04, 4'd13, 32'hC000_000D},  // R4
        {1'b0, 5'h03, 4'd13, 32'hD000_000D},  // R4
        {1'b0, 5'h01, 4'd13, 32'h0000_0000},  // R4
        {1'b0, 5'h02, 4'd13, 32'h0000_0000},  // R3
        {1'b0, 5'h05, 4'd14, 32'hE000_000E},  // R4
        {1'b0, 5'h06, 4'd14, 32'h9000_000E},  // R4
        {1'b0, 5'h07, 4'd8,  32'hB000_0008},  // R5
        {1'b0, 5'h01, 4'd9,  32'h7000_0009},  // R5
        {1'b0, 5'h02, 4'd15, 32'h0000_0F00},  // R2
        {1'b0, 5'h01, 4'd10, 32'h1000_000A},  // R4
        {1'b0, 5'h02, 4'd10, 32'h0000_0000},  // R3
        {1'b0, 5'h01, 4'd12, 32'h1200_000C},  // R6
        {1'b0, 5'h00, 4'd12, 32'h1200_000C}   // R6
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic gpr_write(input logic [4:0] m, input logic [3:0] i, input logic [31:0] d);
        @(negedge clk);
        mode = m; wr_idx = i; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic gpr_read(input logic [4:0] m, input logic [3:0] ia, input logic [3:0] ib);
        @(negedge clk);
        mode = m; rd_a_idx = ia; rd_b_idx = ib;
        #2;
    endtask

    task automatic sav_write(input logic [4:0] m, input logic [31:0] d);
        @(negedge clk);
        mode = m; sav_wdata = d; sav_we = 1'b1;
        @(negedge clk);
        sav_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        gpr_read(5'h01, 4'd0, 4'd15);
        check("R1 r0", rd_a_data, 32'h0);
        check("R1 r15", rd_b_data, 32'h0);
        gpr_read(5'h02, 4'd14, 4'd8);
        check("R1 fast r14", rd_a_data, 32'h0);
        check("R1 cur status", cur_st_rd, 32'h0);
        gpr_read(5'h04, 4'd13, 4'd13);
        check("R1 saved svc", sav_rd, 32'h0);

        // table walk: R2 R3 R4 R5 R6
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][41]) begin
                gpr_write(VEC[k][40:36], VEC[k][35:32], VEC[k][31:0]);
            end else begin
                gpr_read(VEC[k][40:36], VEC[k][35:32], VEC[k][35:32]);
                check($sformatf("R2-R6 table entry %0d port A", k), rd_a_data, VEC[k][31:0]);
                check($sformatf("R2-R6 table entry %0d port B", k), rd_b_data, VEC[k][31:0]);
            end
        end

        // R7: two ports read different registers at once
        gpr_read(5'h04, 4'd8, 4'd13);
        check("R7 port A", rd_a_data, 32'hB000_0008);
        check("R7 port B", rd_b_data, 32'hC000_000D);

        // R8: read during write returns old value
        @(negedge clk);
        mode = 5'h01; rd_a_idx = 4'd1; rd_b_idx = 4'd1;
        wr_idx = 4'd1; wr_data = 32'h5555_AAAA; wr_en = 1'b1;
        #2;
        check("R8 same cycle old value", rd_a_data, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        #2;
        check("R8 next cycle new value", rd_b_data, 32'h5555_AAAA);

        // R9: current status shared
        @(negedge clk);
        mode = 5'h02; cur_st_wdata = 32'hC0FF_EE01; cur_st_we = 1'b1;
        @(negedge clk);
        cur_st_we = 1'b0;
        gpr_read(5'h01, 4'd0, 4'd0);
        check("R9 status in user", cur_st_rd, 32'hC0FF_EE01);
        gpr_read(5'h04, 4'd0, 4'd0);
        check("R9 status in svc", cur_st_rd, 32'hC0FF_EE01);

        // R10: saved status per exception mode
        for (int m = 2; m <= 6; m++)
            sav_write(5'(m), 32'h5000_0000 + 32'(m));
        for (int m = 2; m <= 6; m++) begin
            gpr_read(5'(m), 4'd0, 4'd0);
            check($sformatf("R10 saved mode %0d", m), sav_rd, 32'h5000_0000 + 32'(m));
        end

        // R11: saved status absent in user, system, unknown
        sav_write(5'h01, 32'hDEAD_BEEF);
        gpr_read(5'h01, 4'd0, 4'd0);
        check("R11 user saved zero", sav_rd, 32'h0);
        sav_write(5'h07, 32'hFEED_F00D);
        gpr_read(5'h07, 4'd0, 4'd0);
        check("R11 system saved zero", sav_rd, 32'h0);
        gpr_read(5'h1F, 4'd0, 4'd0);
        check("R11 unknown saved zero", sav_rd, 32'h0);
        for (int m = 2; m <= 6; m++) begin
            gpr_read(5'(m), 4'd0, 4'd0);
            check($sformatf("R11 saved mode %0d untouched", m), sav_rd, 32'h5000_0000 + 32'(m));
        end

        finish_run();
    end
endmodule